// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves data between two ports, A and B, with one storage element for each direction of flow. Data going from A to B passes through its own holding register, and data going from B to A passes through a second one. Each direction is steered by three active-low controls: a chip enable, a latch enable and an output enable. A holding register is open, and follows its source port, only while both its chip enable and its latch enable are low. It keeps its last value once either of those two controls goes high. The far port is driven only while the chip enable and the output enable of that direction are both low.

The design is clocked. An open holding register samples its source port on every rising clock edge. The drive enables are registered too, so every output changes one clock after the inputs that cause it. The width of a section is a parameter. The top level repeats the section, and each section has its own full set of six controls, so two 8-bit sections can run independently or be tied together as one 16-bit path. Each port has a data input, a data output and a drive-enable output, which a pad ring or wrapper can use to build a tristate pin. When both directions of the same section would drive at once, a per-section conflict flag rises in the same cycle as the two drive enables.

Top module: `xbt_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every holding register clears to zero, and both drive enables and the conflict flag of every section go low.
- R2: While a direction's chip enable and latch enable are both low, its holding register loads the source port at each rising edge. The new value appears on the far port's data output after that edge.
- R3: If the latch enable of a direction is high at an edge, the holding register keeps its value, whatever the source port does.
- R4: If the chip enable of a direction is high at an edge, the holding register keeps its value, even while the latch enable is low.
- R5: When chip enable and output enable are both low at an edge, the far port's drive enable is high after that edge. The data output then carries the held value and does not track the source port once the register is closed.
- R6: A high chip enable at an edge makes the far port's drive enable low after that edge, whatever the other controls are.
- R7: A high output enable at an edge makes the far port's drive enable low after that edge, but capture into an open holding register goes on. The captured value shows once the output enable returns low.
- R8: The B-to-A direction (controls `ba_*`, source `b_in`, outputs `a_out`/`a_drv`) behaves like A-to-B and never changes the A-to-B holding register, and the reverse also holds.
- R9: Section k uses control bit k and data bits [k*W +: W] of every data port. Controls of one section never affect another section.
- R10: A section's conflict flag is high after an edge exactly when both its drive enables are high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ab_ce_n | input | NSECT | A-to-B chip enable per section, active low |
| ab_le_n | input | NSECT | A-to-B latch enable per section, active low |
| ab_oe_n | input | NSECT | A-to-B output enable per section, active low |
| ba_ce_n | input | NSECT | B-to-A chip enable per section, active low |
| ba_le_n | input | NSECT | B-to-A latch enable per section, active low |
| ba_oe_n | input | NSECT | B-to-A output enable per section, active low |
| a_in | input | NSECT*W | Data seen on port A |
| b_in | input | NSECT*W | Data seen on port B |
| a_out | output | NSECT*W | B-to-A held data toward port A |
| a_drv | output | NSECT | Port A drive enable per section |
| b_out | output | NSECT*W | A-to-B held data toward port B |
| b_drv | output | NSECT | Port B drive enable per section |
| conflict | output | NSECT | Both directions of the section driving at once |

## Verification
The assertions check the following on every cycle: the hold rule when a direction is closed, loading while open, the drive-enable response to chip enable and output enable, and the agreement between the conflict flag and the two drive enables. Other behaviours need the bench's scenarios and its clock-by-clock reference model. These are the value that survives a close by latch enable compared with a close by chip enable, the capture that goes on while output is disabled, the isolation between the two directions and between sections, and the mapping of sections onto bit slices.

// File: rtl/xbt_pkg.sv
package xbt_pkg;

  // Control set for one direction of one section (all active low)
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } xbt_ctl_t;

  function automatic logic xbt_open(input xbt_ctl_t c);
    return !c.ce_n && !c.le_n;
  endfunction

  function automatic logic xbt_drive(input xbt_ctl_t c);
    return !c.ce_n && !c.oe_n;
  endfunction

endpackage

// File: rtl/xbt_lane.sv
module xbt_lane
  import xbt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xbt_ctl_t     ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drv
);

  logic [W-1:0] hold_q;
  logic         drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      if (xbt_open(ctl))
        hold_q <= din;
      drv_q <= xbt_drive(ctl);
    end
  end

  assign dout = hold_q;
  assign drv  = drv_q;

  AST_LANE_RESET: assert property (@(posedge clk)
    rst |=> (dout == '0 && !drv)); // R1

  AST_LANE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && !ctl.le_n) |=> (dout == $past(din))); // R2

  AST_LANE_HOLD_LE: assert property (@(posedge clk) disable iff (rst)
    ctl.le_n |=> $stable(dout)); // R3

  AST_LANE_HOLD_CE: assert property (@(posedge clk) disable iff (rst)
    ctl.ce_n |=> $stable(dout)); // R4

  AST_LANE_DRIVE_ON: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && !ctl.oe_n) |=> drv); // R5

  AST_LANE_CE_OFF: assert property (@(posedge clk) disable iff (rst)
    ctl.ce_n |=> !drv); // R6

  AST_LANE_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    ctl.oe_n |=> !drv); // R7

endmodule

// File: rtl/xbt_section.sv
module xbt_section
  import xbt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xbt_ctl_t     ab_ctl,
  input  xbt_ctl_t     ba_ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic         conflict
);

  logic conflict_q;

  xbt_lane #(.W(W)) u_ab (
    .clk (clk),
    .rst (rst),
    .ctl (ab_ctl),
    .din (a_in),
    .dout(b_out),
    .drv (b_drv)
  );

  xbt_lane #(.W(W)) u_ba (
    .clk (clk),
    .rst (rst),
    .ctl (ba_ctl),
    .din (b_in),
    .dout(a_out),
    .drv (a_drv)
  );

  always_ff @(posedge clk) begin
    if (rst)
      conflict_q <= 1'b0;
    else
      conflict_q <= xbt_drive(ab_ctl) && xbt_drive(ba_ctl);
  end

  assign conflict = conflict_q;

  AST_CONFLICT_MATCH: assert property (@(posedge clk) disable iff (rst)
    conflict == (a_drv && b_drv)); // R10

  AST_AB_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (ab_ctl.ce_n || ab_ctl.le_n) |=> $stable(b_out)); // R8

  AST_BA_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (ba_ctl.ce_n || ba_ctl.le_n) |=> $stable(a_out)); // R8

endmodule

// File: rtl/xbt_top.sv
module xbt_top
  import xbt_pkg::*;
#(
  parameter int W     = 8,
  parameter int NSECT = 2,
  localparam int TW   = W * NSECT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSECT-1:0] ab_ce_n,
  input  logic [NSECT-1:0] ab_le_n,
  input  logic [NSECT-1:0] ab_oe_n,
  input  logic [NSECT-1:0] ba_ce_n,
  input  logic [NSECT-1:0] ba_le_n,
  input  logic [NSECT-1:0] ba_oe_n,
  input  logic [TW-1:0]   a_in,
  input  logic [TW-1:0]   b_in,
  output logic [TW-1:0]   a_out,
  output logic [NSECT-1:0] a_drv,
  output logic [TW-1:0]   b_out,
  output logic [NSECT-1:0] b_drv,
  output logic [NSECT-1:0] conflict
);

  for (genvar k = 0; k < NSECT; k++) begin : g_sect
    xbt_ctl_t ab_c;
    xbt_ctl_t ba_c;

    assign ab_c = '{ce_n: ab_ce_n[k], le_n: ab_le_n[k], oe_n: ab_oe_n[k]};
    assign ba_c = '{ce_n: ba_ce_n[k], le_n: ba_le_n[k], oe_n: ba_oe_n[k]};

    xbt_section #(.W(W)) u_sect (
      .clk     (clk),
      .rst     (rst),
      .ab_ctl  (ab_c),
      .ba_ctl  (ba_c),
      .a_in    (a_in[k*W +: W]),
      .b_in    (b_in[k*W +: W]),
      .a_out   (a_out[k*W +: W]),
      .a_drv   (a_drv[k]),
      .b_out   (b_out[k*W +: W]),
      .b_drv   (b_drv[k]),
      .conflict(conflict[k])
    );

    // R9: a section closed on both sides keeps its slices frozen
    AST_SECT_SLICE: assert property (@(posedge clk) disable iff (rst)
      (ab_ce_n[k] && ba_ce_n[k]) |=>
        ($stable(b_out[k*W +: W]) && $stable(a_out[k*W +: W]))); // R9
  end

endmodule

// File: tb/sim_xbt_top.sv
module sim_xbt_top;

  localparam int W  = 8;
  localparam int NS = 2;
  localparam int TW = W * NS;

  logic          clk = 1'b0;
  logic          rst;
  logic [NS-1:0] ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
  logic [TW-1:0] a_in, b_in;
  logic [TW-1:0] a_out, b_out;
  logic [NS-1:0] a_drv, b_drv, conflict;

  xbt_top #(.W(W), .NSECT(NS)) u0 (
    .clk(clk), .rst(rst),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
    .conflict(conflict)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done   = 0;
  string tag    = "R1";

  // Behavioural reference: one held value and drive bit per direction per section
  logic [W-1:0] m_ab [NS];
  logic [W-1:0] m_ba [NS];
  bit           m_bd [NS];
  bit           m_ad [NS];

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    for (int k = 0; k < NS; k++) begin
      if (rst) begin
        m_ab[k] = '0; m_ba[k] = '0; m_bd[k] = 0; m_ad[k] = 0;
      end else begin
        if (!ab_ce_n[k] && !ab_le_n[k]) m_ab[k] = a_in[k*W +: W];
        if (!ba_ce_n[k] && !ba_le_n[k]) m_ba[k] = b_in[k*W +: W];
        m_bd[k] = !ab_ce_n[k] && !ab_oe_n[k];
        m_ad[k] = !ba_ce_n[k] && !ba_oe_n[k];
      end
    end
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      chk($sformatf("b_out[%0d]", k), int'(b_out[k*W +: W]), int'(m_ab[k]));
      chk($sformatf("a_out[%0d]", k), int'(a_out[k*W +: W]), int'(m_ba[k]));
      chk($sformatf("b_drv[%0d]", k), int'(b_drv[k]), int'(m_bd[k]));
      chk($sformatf("a_drv[%0d]", k), int'(a_drv[k]), int'(m_ad[k]));
      chk($sformatf("conflict[%0d]", k), int'(conflict[k]), int'(m_bd[k] && m_ad[k]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst = 1;
    ab_ce_n = '0; ab_le_n = '0; ab_oe_n = '0;
    ba_ce_n = '0; ba_le_n = '0; ba_oe_n = '0;
    a_in = 16'h5aa5; b_in = 16'hc33c;
    @(negedge clk);
    tag = "R1";
    repeat (3) step();
    rst = 0;
    ab_ce_n = '1; ba_ce_n = '1; ab_le_n = '1; ba_le_n = '1; ab_oe_n = '1; ba_oe_n = '1;
    step();

    // R2: A-to-B open, outputs enabled, data walks
    tag = "R2";
    ab_ce_n = '0; ab_le_n = '0; ab_oe_n = '0;
    for (int i = 0; i < 6; i++) begin
      a_in = 16'h1111 * (i + 1);
      step();
    end
    a_in = 16'h3c7e; step();

    // R3: close by latch enable, then wiggle A
    tag = "R3";
    ab_le_n = '1;
    for (int i = 0; i < 4; i++) begin a_in = 16'h0f0f ^ (16'h1234 * i); step(); end

    // R4: reopen, then close by chip enable with latch enable still low
    tag = "R4";
    ab_le_n = '0; a_in = 16'hbeef; step();
    ab_ce_n = '1; a_in = 16'h0000; step();
    a_in = 16'hffff; step();

    // R6: chip enable high kills drive regardless of others
    tag = "R6";
    ab_oe_n = '0; step(); step();

    // R7: output disabled while still capturing
    tag = "R7";
    ab_ce_n = '0; ab_le_n = '0; ab_oe_n = '1;
    a_in = 16'h9a6b; step();
    a_in = 16'h4d2e; step();
    ab_le_n = '1; ab_oe_n = '0; a_in = 16'h0101; step(); step();

    // R5: stored value presented, input ignored
    tag = "R5";
    for (int i = 0; i < 3; i++) begin a_in = 16'h7700 + 16'(i); step(); end

    // R8: B-to-A mirror, A-to-B held
    tag = "R8";
    ba_ce_n = '0; ba_le_n = '0; ba_oe_n = '1;
    for (int i = 0; i < 4; i++) begin b_in = 16'h2468 + 16'(i * 16'h0313); step(); end
    ba_le_n = '1; b_in = 16'hdead; step(); step();

    // R9: sections on separate controls
    tag = "R9";
    ab_ce_n = 2'b10; ab_le_n = 2'b10; ab_oe_n = 2'b00;
    ba_ce_n = 2'b01; ba_le_n = 2'b01; ba_oe_n = 2'b11;
    a_in = 16'habcd; b_in = 16'h8642; step();
    a_in = 16'h1357; b_in = 16'h9bdf; step(); step();

    // R10: both directions driving
    tag = "R10";
    ab_ce_n = '0; ab_oe_n = '0; ba_ce_n = '0; ba_oe_n = 2'b10;
    step(); step();
    ba_oe_n = '1; step();

    // Mixed traffic across every control combination
    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      {ab_ce_n, ab_le_n, ab_oe_n} = 6'($urandom);
      {ba_ce_n, ba_le_n, ba_oe_n} = 6'($urandom);
      a_in = 16'($urandom);
      b_in = 16'($urandom);
      rst  = ($urandom_range(0, 60) == 0);
      step();
    end
    rst = 0;
    finish_run();
  end

endmodule